// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This combinational unit sits between an execute stage and a 64-bit wide data memory port. On the request side it receives a 32-bit load or store instruction word, the base register value and the store source value. It decodes the instruction and forms the effective address. It then produces:

- a doubleword-aligned memory address;
- a per-byte lane enable mask;
- write data moved into the lanes that the access touches.

Any access whose address is not a multiple of its size is refused with a fault flag.

On the response side it receives the doubleword returned by memory, together with the byte offset and function code of the load. It moves the addressed bytes down to bit 0, then sign-extends or zero-extends them to the full register width. The two sides are independent, so a load response can be processed in the same cycle as a new request.

Top module: `lane_align_unit`

## Requirements
- R1: The effective address is base_val plus a sign-extended 12-bit offset. For a load the offset is taken from instruction bits [31:20]. For a store, instruction bits [31:25] form offset bits [11:5] and instruction bits [11:7] form offset bits [4:0]. mem_addr is the effective address with its low 3 bits cleared.
- R2: A load is recognised only when acc_valid is 1 and instruction bits [6:0] are 0000011; it then raises mem_rd. A store is recognised only when acc_valid is 1 and those bits are 0100011; it then raises mem_wr. For anything else, mem_rd, mem_wr, misalign and every bit of mem_byte_en are 0.
- R3: The access size in bytes is 1 << funct3[1:0], where funct3 is instruction bits [14:12]. A recognised, aligned access enables that many consecutive lanes, starting at lane effective_address[2:0]. Lane i covers data bits [8i+7:8i].
- R4: An access whose effective address is not a multiple of its size raises misalign. mem_rd, mem_wr and every bit of mem_byte_en then stay 0.
- R5: For an aligned store, the low size bytes of store_val appear in the enabled lanes of mem_wr_data and all other lanes are zero. Store funct3 bit 2 is ignored, so store funct3 100 behaves as 000.
- R6: For load funct3 000, 001 and 010, the 1, 2 or 4 selected bytes are sign-extended to 64 bits.
- R7: For load funct3 100, 101 and 110, the 1, 2 or 4 selected bytes are zero-extended to 64 bits.
- R8: Load funct3 011 and 111 return all 64 bits of rsp_dword unchanged when rsp_offset is 0.
- R9: Before extension, rsp_dword is shifted right by rsp_offset bytes, so byte rsp_offset becomes bit 0 of load_value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_valid | input | 1 | An instruction is presented this cycle |
| instr_word | input | 32 | Load or store instruction word |
| base_val | input | 64 | Base register value |
| store_val | input | 64 | Store source register value |
| mem_addr | output | 64 | Doubleword-aligned memory address |
| mem_byte_en | output | 8 | Per-lane enable mask |
| mem_wr_data | output | 64 | Lane-placed write data |
| mem_rd | output | 1 | Aligned load issued |
| mem_wr | output | 1 | Aligned store issued |
| misalign | output | 1 | Access refused as misaligned |
| rsp_offset | input | 3 | Byte offset of the returning load |
| rsp_funct3 | input | 3 | Function code of the returning load |
| rsp_dword | input | 64 | Doubleword read from memory |
| load_value | output | 64 | Extracted, extended load result |

## Verification
The unit holds no state, so any wrong decode, mask or shift shows at the outputs in the same cycle as the input that triggers it. A misdecoded split offset shows up as a wrong mem_addr or lane mask. A size or offset slip produces a mask with the wrong lane count or position, write data outside the enabled lanes, or a load result drawn from the wrong bytes. Corner cases include:

- negative offsets that borrow across the upper address bits;
- the highest lane offsets;
- misaligned halfword, word and doubleword accesses;
- bytes whose top bit decides between sign fill and zero fill.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

   localparam logic [6:0] OPC_LOAD  = 7'b0000011;
   localparam logic [6:0] OPC_STORE = 7'b0100011;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   typedef struct packed {
      logic       is_load;
      logic       is_store;
      acc_size_e  size;
      logic [11:0] offs;
   } acc_decode_t;

   function automatic acc_decode_t decode_access(input logic [31:0] iw, input logic valid);
      acc_decode_t d;
      d.is_load  = valid && (iw[6:0] == OPC_LOAD);
      d.is_store = valid && (iw[6:0] == OPC_STORE);
      d.size     = acc_size_e'(iw[13:12]);
      d.offs     = d.is_store ? {iw[31:25], iw[11:7]} : iw[31:20];
      return d;
   endfunction

endpackage

// File: rtl/lau_addr_gen.sv
module lau_addr_gen
   import lane_align_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic              acc_valid,
   input  logic [31:0]       instr_word,
   input  logic [XLEN-1:0]   base_val,
   output acc_decode_t       dec,
   output logic [XLEN-1:0]   eff_addr
);
   localparam int OFFS_W = 12;

   logic [XLEN-1:0] offs_sext;

   assign dec       = decode_access(instr_word, acc_valid);
   assign offs_sext = {{(XLEN-OFFS_W){dec.offs[OFFS_W-1]}}, dec.offs};
   assign eff_addr  = base_val + offs_sext;
endmodule

// File: rtl/lau_store_lanes.sv
module lau_store_lanes
   import lane_align_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter bit REPLICATE = 1'b0
) (
   input  acc_decode_t                    dec,
   input  logic [$clog2(XLEN/8)-1:0]      lane_off,
   input  logic [XLEN-1:0]                store_val,
   output logic [XLEN/8-1:0]              byte_en,
   output logic [XLEN-1:0]                wr_data,
   output logic                           misalign
);
   localparam int LANES = XLEN / 8;
   localparam int OFFW  = $clog2(LANES);

   logic [3:0]       nbytes;
   logic [OFFW-1:0]  sz_mask;
   logic             access;
   logic [LANES-1:0] base_mask;
   logic [XLEN-1:0]  trimmed;
   logic [XLEN-1:0]  placed;

   assign nbytes   = 4'd1 << dec.size;
   assign sz_mask  = OFFW'(nbytes - 4'd1);
   assign access   = dec.is_load | dec.is_store;
   assign misalign = access & (|(lane_off & sz_mask));

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         base_mask[i]     = (i < int'(nbytes));
         trimmed[8*i +: 8] = base_mask[i] ? store_val[8*i +: 8] : 8'h00;
      end
   end

   generate
      if (REPLICATE) begin : g_replicate
         always_comb begin
            for (int i = 0; i < LANES; i++) begin
               placed[8*i +: 8] = store_val[8*(i & (int'(nbytes) - 1)) +: 8];
            end
         end
      end else begin : g_shift
         assign placed = trimmed << {lane_off, 3'b000};
      end
   endgenerate

   assign byte_en = (access && !misalign) ? (base_mask << lane_off) : '0;
   assign wr_data = (dec.is_store && !misalign) ? placed : '0;
endmodule

// File: rtl/lau_load_extract.sv
module lau_load_extract
   import lane_align_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [$clog2(XLEN/8)-1:0] rsp_offset,
   input  logic [2:0]                rsp_funct3,
   input  logic [XLEN-1:0]           rsp_dword,
   output logic [XLEN-1:0]           load_value
);
   localparam int LANES = XLEN / 8;

   acc_size_e        size;
   logic [3:0]       nbytes;
   logic [XLEN-1:0]  shifted;
   logic             top_bit;
   logic             fill;

   assign size    = acc_size_e'(rsp_funct3[1:0]);
   assign nbytes  = 4'd1 << size;
   assign shifted = rsp_dword >> {rsp_offset, 3'b000};

   always_comb begin
      unique case (size)
         SZ_BYTE: top_bit = shifted[7];
         SZ_HALF: top_bit = shifted[15];
         SZ_WORD: top_bit = shifted[31];
         default: top_bit = shifted[63];
      endcase
   end

   assign fill = top_bit & ~rsp_funct3[2];

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         load_value[8*i +: 8] = (i < int'(nbytes)) ? shifted[8*i +: 8] : {8{fill}};
      end
   end
endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
   import lane_align_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter bit REPLICATE = 1'b0
) (
   input  logic                       acc_valid,
   input  logic [31:0]                instr_word,
   input  logic [XLEN-1:0]            base_val,
   input  logic [XLEN-1:0]            store_val,
   output logic [XLEN-1:0]            mem_addr,
   output logic [XLEN/8-1:0]          mem_byte_en,
   output logic [XLEN-1:0]            mem_wr_data,
   output logic                       mem_rd,
   output logic                       mem_wr,
   output logic                       misalign,
   input  logic [$clog2(XLEN/8)-1:0]  rsp_offset,
   input  logic [2:0]                 rsp_funct3,
   input  logic [XLEN-1:0]            rsp_dword,
   output logic [XLEN-1:0]            load_value
);
   localparam int LANES = XLEN / 8;
   localparam int OFFW  = $clog2(LANES);

   generate
      if (XLEN < 64 || (XLEN % 8) != 0 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_width
         $error("lane_align_unit: XLEN must be a power of two of at least 64");
      end
   endgenerate

   acc_decode_t     dec;
   logic [XLEN-1:0] eff_addr;

   lau_addr_gen #(.XLEN(XLEN)) u_addr (
      .acc_valid  (acc_valid),
      .instr_word (instr_word),
      .base_val   (base_val),
      .dec        (dec),
      .eff_addr   (eff_addr)
   );

   lau_store_lanes #(.XLEN(XLEN), .REPLICATE(REPLICATE)) u_lanes (
      .dec       (dec),
      .lane_off  (eff_addr[OFFW-1:0]),
      .store_val (store_val),
      .byte_en   (mem_byte_en),
      .wr_data   (mem_wr_data),
      .misalign  (misalign)
   );

   lau_load_extract #(.XLEN(XLEN)) u_extract (
      .rsp_offset (rsp_offset),
      .rsp_funct3 (rsp_funct3),
      .rsp_dword  (rsp_dword),
      .load_value (load_value)
   );

   assign mem_addr = {eff_addr[XLEN-1:OFFW], {OFFW{1'b0}}};
   assign mem_rd   = dec.is_load  & ~misalign;
   assign mem_wr   = dec.is_store & ~misalign;
endmodule

// File: rtl/lane_align_unit_chk.sv
module lane_align_unit_chk #(
   parameter int XLEN      = 64,
   parameter bit REPLICATE = 1'b0
) (
   input logic                       acc_valid,
   input logic [31:0]                instr_word,
   input logic [XLEN-1:0]            base_val,
   input logic [XLEN-1:0]            store_val,
   input logic [XLEN-1:0]            mem_addr,
   input logic [XLEN/8-1:0]          mem_byte_en,
   input logic [XLEN-1:0]            mem_wr_data,
   input logic                       mem_rd,
   input logic                       mem_wr,
   input logic                       misalign,
   input logic [$clog2(XLEN/8)-1:0]  rsp_offset,
   input logic [2:0]                 rsp_funct3,
   input logic [XLEN-1:0]            rsp_dword,
   input logic [XLEN-1:0]            load_value
);
   localparam int LANES = XLEN / 8;
   localparam int OFFW  = $clog2(LANES);

   logic [XLEN-1:0] lane_bits;

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         lane_bits[8*i +: 8] = {8{mem_byte_en[i]}};
      end
   end

   always_comb begin
      AST_ADDR_ALIGNED: assert (mem_addr[OFFW-1:0] == '0); // R1
      AST_SINGLE_COMMAND: assert (!(mem_rd && mem_wr)); // R2
      AST_IDLE_QUIET: assert (acc_valid || (!mem_rd && !mem_wr && !misalign && mem_byte_en == '0)); // R2
      AST_LANE_COUNT: assert (!(mem_rd || mem_wr) || ($countones(mem_byte_en) inside {1, 2, 4, 8})); // R3
      AST_FAULT_BLOCKS: assert (!misalign || (!mem_rd && !mem_wr && mem_byte_en == '0)); // R4
      AST_WDATA_IN_LANES: assert (REPLICATE || ((mem_wr_data & ~lane_bits) == '0)); // R5
      AST_SIGN_FILL: assert (rsp_funct3[2] || rsp_funct3[1:0] == 2'b11
                             || load_value[XLEN-1:32] == '0 || load_value[XLEN-1:32] == '1); // R6
      AST_ZERO_FILL: assert (!rsp_funct3[2] || rsp_funct3[1:0] == 2'b11
                             || load_value[XLEN-1:32] == '0); // R7
   end
endmodule

bind lane_align_unit lane_align_unit_chk #(.XLEN(XLEN), .REPLICATE(REPLICATE)) u_chk (.*);

// File: tb/lane_align_unit_test.sv
module lane_align_unit_test;

   localparam logic [6:0] T_LOAD  = 7'b0000011;
   localparam logic [6:0] T_STORE = 7'b0100011;
   localparam logic [6:0] T_ALU   = 7'b0110011;
   localparam logic [63:0] SDATA  = 64'h8877_6655_4433_2211;
   localparam logic [63:0] RDATA  = 64'h8172_63D4_B5A6_1788;

   logic        clk = 1'b0;
   logic        acc_valid;
   logic [31:0] instr_word;
   logic [63:0] base_val, store_val, mem_addr, mem_wr_data, rsp_dword, load_value;
   logic [7:0]  mem_byte_en;
   logic        mem_rd, mem_wr, misalign;
   logic [2:0]  rsp_offset, rsp_funct3;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   lane_align_unit uut (
      .acc_valid   (acc_valid),
      .instr_word  (instr_word),
      .base_val    (base_val),
      .store_val   (store_val),
      .mem_addr    (mem_addr),
      .mem_byte_en (mem_byte_en),
      .mem_wr_data (mem_wr_data),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .misalign    (misalign),
      .rsp_offset  (rsp_offset),
      .rsp_funct3  (rsp_funct3),
      .rsp_dword   (rsp_dword),
      .load_value  (load_value)
   );

   typedef struct packed {
      logic [6:0]  opc;
      logic [2:0]  f3;
      logic [11:0] offs;
      logic [63:0] base;
      logic [63:0] addr;
      logic [7:0]  be;
      logic [63:0] wdata;
      logic        rd;
      logic        wr;
      logic        mis;
   } req_vec_t;

   localparam int NREQ = 13;
   localparam req_vec_t REQ_TAB [NREQ] = '{
      '{T_STORE, 3'b000, 12'h005, 64'h1000, 64'h1000, 8'h20, 64'h0000_1100_0000_0000, 1'b0, 1'b1, 1'b0}, // R3 R5 byte
      '{T_STORE, 3'b001, 12'hFFE, 64'h2000, 64'h1FF8, 8'hC0, 64'h2211_0000_0000_0000, 1'b0, 1'b1, 1'b0}, // R1 negative offset
      '{T_STORE, 3'b010, 12'h7FC, 64'h3000, 64'h37F8, 8'hF0, 64'h4433_2211_0000_0000, 1'b0, 1'b1, 1'b0}, // R5 word
      '{T_STORE, 3'b011, 12'h010, 64'h4000, 64'h4010, 8'hFF, SDATA,                   1'b0, 1'b1, 1'b0}, // R5 dword
      '{T_STORE, 3'b001, 12'h003, 64'h5000, 64'h5000, 8'h00, 64'h0,                   1'b0, 1'b0, 1'b1}, // R4 half
      '{T_STORE, 3'b010, 12'h006, 64'h6000, 64'h6000, 8'h00, 64'h0,                   1'b0, 1'b0, 1'b1}, // R4 word
      '{T_STORE, 3'b011, 12'h004, 64'h7000, 64'h7000, 8'h00, 64'h0,                   1'b0, 1'b0, 1'b1}, // R4 dword
      '{T_STORE, 3'b100, 12'h001, 64'h8000, 64'h8000, 8'h02, 64'h0000_0000_0000_1100, 1'b0, 1'b1, 1'b0}, // R5 bit2 ignored
      '{T_STORE, 3'b000, 12'h821, 64'h10000, 64'hF820, 8'h02, 64'h0000_0000_0000_1100, 1'b0, 1'b1, 1'b0}, // R1 split offset
      '{T_LOAD,  3'b010, 12'h00C, 64'h100,  64'h108,  8'hF0, 64'h0,                   1'b1, 1'b0, 1'b0}, // R3 load
      '{T_LOAD,  3'b100, 12'hFFF, 64'h100,  64'hF8,   8'h80, 64'h0,                   1'b1, 1'b0, 1'b0}, // R3 top lane
      '{T_LOAD,  3'b011, 12'h002, 64'h0,    64'h0,    8'h00, 64'h0,                   1'b0, 1'b0, 1'b1}, // R4 load
      '{T_LOAD,  3'b101, 12'h7FF, 64'h1,    64'h800,  8'h03, 64'h0,                   1'b1, 1'b0, 1'b0}  // R1 load offset
   };

   typedef struct packed {
      logic [2:0]  off;
      logic [2:0]  f3;
      logic [63:0] expv;
   } rsp_vec_t;

   localparam int NRSP = 13;
   localparam rsp_vec_t RSP_TAB [NRSP] = '{
      '{3'd0, 3'b000, 64'hFFFF_FFFF_FFFF_FF88}, // R6 negative byte
      '{3'd0, 3'b100, 64'h0000_0000_0000_0088}, // R7 unsigned byte
      '{3'd1, 3'b000, 64'h0000_0000_0000_0017}, // R9 positive byte
      '{3'd5, 3'b000, 64'h0000_0000_0000_0063}, // R9 offset 5
      '{3'd2, 3'b001, 64'hFFFF_FFFF_FFFF_B5A6}, // R6 half
      '{3'd2, 3'b101, 64'h0000_0000_0000_B5A6}, // R7 half
      '{3'd6, 3'b001, 64'hFFFF_FFFF_FFFF_8172}, // R9 top half
      '{3'd4, 3'b001, 64'h0000_0000_0000_63D4}, // R6 positive half
      '{3'd4, 3'b010, 64'hFFFF_FFFF_8172_63D4}, // R6 word
      '{3'd4, 3'b110, 64'h0000_0000_8172_63D4}, // R7 word
      '{3'd0, 3'b010, 64'hFFFF_FFFF_B5A6_1788}, // R6 low word
      '{3'd0, 3'b011, RDATA},                   // R8 dword
      '{3'd0, 3'b111, RDATA}                    // R8 funct3 111
   };

   function automatic logic [31:0] make_instr(input logic [6:0] opc, input logic [2:0] f3,
                                               input logic [11:0] offs);
      if (opc == T_STORE) return {offs[11:5], 5'd2, 5'd1, f3, offs[4:0], opc};
      return {offs, 5'd1, f3, 5'd3, opc};
   endfunction

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      acc_valid  = 1'b0;
      instr_word = '0;
      base_val   = '0;
      store_val  = '0;
      rsp_offset = '0;
      rsp_funct3 = '0;
      rsp_dword  = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R2 reset byte_en", 64'(mem_byte_en), 64'h0);
      check("R2 reset rd/wr/misalign", {61'h0, mem_rd, mem_wr, misalign}, 64'h0);
      check("R9 reset load_value", load_value, 64'h0);

      for (int k = 0; k < NREQ; k++) begin
         @(posedge clk);
         acc_valid  = 1'b1;
         instr_word = make_instr(REQ_TAB[k].opc, REQ_TAB[k].f3, REQ_TAB[k].offs);
         base_val   = REQ_TAB[k].base;
         store_val  = SDATA;
         @(negedge clk);
         check($sformatf("R1 addr vec %0d", k), mem_addr, REQ_TAB[k].addr);
         check($sformatf("R3 byte_en vec %0d", k), 64'(mem_byte_en), 64'(REQ_TAB[k].be));
         check($sformatf("R5 wr_data vec %0d", k), mem_wr_data, REQ_TAB[k].wdata);
         check($sformatf("R2 rd/wr vec %0d", k), {62'h0, mem_rd, mem_wr},
               {62'h0, REQ_TAB[k].rd, REQ_TAB[k].wr});
         check($sformatf("R4 misalign vec %0d", k), 64'(misalign), 64'(REQ_TAB[k].mis));
      end

      for (int k = 0; k < NRSP; k++) begin
         @(posedge clk);
         rsp_offset = RSP_TAB[k].off;
         rsp_funct3 = RSP_TAB[k].f3;
         rsp_dword  = RDATA;
         @(negedge clk);
         check($sformatf("R9 R6 R7 R8 load vec %0d", k), load_value, RSP_TAB[k].expv);
      end

      // R2: a store word with acc_valid low issues nothing
      @(posedge clk);
      acc_valid  = 1'b0;
      instr_word = make_instr(T_STORE, 3'b011, 12'h003);
      base_val   = 64'h9000;
      @(negedge clk);
      check("R2 invalid byte_en", 64'(mem_byte_en), 64'h0);
      check("R2 invalid flags", {61'h0, mem_rd, mem_wr, misalign}, 64'h0);

      // R2: a register-register opcode is neither load nor store
      @(posedge clk);
      acc_valid  = 1'b1;
      instr_word = 32'h015A_04B3;
      @(negedge clk);
      check("R2 other opcode byte_en", 64'(mem_byte_en), 64'h0);
      check("R2 other opcode flags", {61'h0, mem_rd, mem_wr, misalign}, 64'h0);
      check("R2 other opcode wr_data", mem_wr_data, 64'h0);

      // R3: byte store at lane 7 enables only the top lane
      @(posedge clk);
      instr_word = make_instr(T_STORE, 3'b000, 12'h007);
      base_val   = 64'hA000;
      @(negedge clk);
      check("R3 top lane byte_en", 64'(mem_byte_en), 64'h80);
      check("R5 top lane wr_data", mem_wr_data, 64'h1100_0000_0000_0000);

      // R1: address carry across the upper bits
      @(posedge clk);
      instr_word = make_instr(T_LOAD, 3'b011, 12'h008);
      base_val   = 64'h0000_0000_FFFF_FFF8;
      @(negedge clk);
      check("R1 carry addr", mem_addr, 64'h0000_0001_0000_0000);
      check("R3 carry byte_en", 64'(mem_byte_en), 64'hFF);

      // R9: word from the upper half of an all-ones-high doubleword, unsigned
      @(posedge clk);
      acc_valid  = 1'b0;
      rsp_offset = 3'd4;
      rsp_funct3 = 3'b110;
      rsp_dword  = 64'hFFFF_FFFF_0000_0000;
      @(negedge clk);
      check("R7 R9 unsigned high word", load_value, 64'h0000_0000_FFFF_FFFF);
      @(posedge clk);
      rsp_funct3 = 3'b010;
      @(negedge clk);
      check("R6 R9 signed high word", load_value, 64'hFFFF_FFFF_FFFF_FFFF);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule